// File: doc/BRIEF.md
# Processor Control Register Bank with Banked Stack Pointer

This block holds the control state of a small processor core: the status word and its backup copy, a second-level backup status, the condition flag, two stack-pointer shadows (one for interrupt mode, one for user mode), two backup program counters and two spare scratch registers. It has one combinational read port and one synchronous write port, both addressed by a 4-bit control-register number. It also has a side port to the live stack pointer, which is general register R15 in the general register file outside this block.

The status word carries a stack-mode bit in bit 7. A write that flips this bit exchanges the live stack pointer with the shadow copy that belongs to the new mode, through the side port. While a mode is active, the shadow register of that mode is an alias of the live register, so reads and writes to it go to R15. Reads of several registers are masked or composed, so that only the architecturally defined bits are visible.

Top module: `ctrl_regfile`

## Requirements
- R1: Reading number 0 returns a composed status word: bits 15:8 are the stored backup status ANDed with 0xC1, bits 7:6 are the current status bits 7:6, bit 0 is the condition flag, and every other bit is zero.
- R2: Writing number 0 stores bits 15:8 as the backup status and bits 7:6 as the current status, and sets the condition flag from bit 0. The new values are visible on the read port from the cycle after the write edge.
- R3: A write to number 0 that takes status bit 7 (stack mode) from 0 to 1 asserts sp_wr_en with the interrupt shadow value on sp_wr_data in that same cycle, and stores the current sp_rd_data into the user shadow.
- R4: A write to number 0 that takes stack mode from 1 to 0 asserts sp_wr_en with the user shadow value on sp_wr_data, and stores the current sp_rd_data into the interrupt shadow. A status write that leaves stack mode unchanged does not assert sp_wr_en.
- R5: With stack mode 1, number 2 (interrupt SP) reads sp_rd_data, and a write to it asserts sp_wr_en and leaves the shadow unchanged. With stack mode 0, number 3 (user SP) behaves the same way. The other stack-pointer number reads and writes its own 32-bit shadow. sp_wr_en is never asserted without wr_en.
- R6: Numbers 6 and 9 (backup PC and second-level backup PC) store all 32 written bits and read back with bit 0 forced to zero.
- R7: Number 8 (second-level backup status) stores the low 8 bits of a write and reads back that byte ANDed with 0xC1, with upper bits zero.
- R8: Writing number 1 changes only the condition flag, taken from bit 0. Reading number 1 returns the flag in bit 0 and zeros elsewhere.
- R9: Numbers 4 and 5 are plain 32-bit read/write storage.
- R10: Numbers 7 and 10 to 15 read as zero, and writes to them change no state and assert no side-port write.
- R11: After reset, all stored registers are zero and stack mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_idx | input | 4 | Control-register number for the read port |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Control-register number for the write port |
| wr_data | input | 32 | Write data |
| sp_rd_data | input | 32 | Current value of the live stack pointer (R15) |
| sp_wr_en | output | 1 | Request to load the live stack pointer at this clock edge |
| sp_wr_data | output | 32 | Value to load into the live stack pointer |

## Verification
The bench builds the block with its default 32-bit data width and two spare registers. This puts every masked field of the status words, the full-width backup PCs and both spare slots within reach of random data. The bench keeps its own model of R15 and sometimes overwrites it between control-register accesses, the way unrelated instructions would. Random operations are weighted toward the status word and the two stack-pointer numbers, so that mode flips, repeated same-mode writes and aliased accesses in both modes all occur many times.

// File: rtl/ctrl_regfile_pkg.sv
package ctrl_regfile_pkg;
  localparam int IDX_W = 4;

  // control-register numbers
  localparam logic [IDX_W-1:0] CR_STATUS  = 4'd0;
  localparam logic [IDX_W-1:0] CR_COND    = 4'd1;
  localparam logic [IDX_W-1:0] CR_ISP     = 4'd2;
  localparam logic [IDX_W-1:0] CR_USP     = 4'd3;
  localparam int               SPARE_BASE = 4;
  localparam logic [IDX_W-1:0] CR_BPC     = 4'd6;
  localparam logic [IDX_W-1:0] CR_BBSTAT  = 4'd8;
  localparam logic [IDX_W-1:0] CR_BBPC    = 4'd9;

  // visible bits of the backup status bytes
  localparam logic [7:0] FLAG_MASK = 8'hC1;
  localparam int         MODE_BIT  = 7;
endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/crf_wr_decode.sv
module crf_wr_decode
  import ctrl_regfile_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SPARE = 2
) (
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   stack_mode,
  input  logic [DATA_W-1:0]      sp_rd_data,
  input  logic [DATA_W-1:0]      isp_q,
  input  logic [DATA_W-1:0]      usp_q,
  output logic                   stat_we,
  output logic                   cond_we,
  output logic                   isp_we,
  output logic [DATA_W-1:0]      isp_val,
  output logic                   usp_we,
  output logic [DATA_W-1:0]      usp_val,
  output logic                   bpc_we,
  output logic                   bbpc_we,
  output logic                   bbstat_we,
  output logic [NUM_SPARE-1:0]   spare_we,
  output logic                   sp_wr_en,
  output logic [DATA_W-1:0]      sp_wr_data
);
  logic mode_flip;
  assign mode_flip = (wr_data[MODE_BIT] != stack_mode);

  always_comb begin
    stat_we    = 1'b0;
    cond_we    = 1'b0;
    isp_we     = 1'b0;
    isp_val    = wr_data;
    usp_we     = 1'b0;
    usp_val    = wr_data;
    bpc_we     = 1'b0;
    bbpc_we    = 1'b0;
    bbstat_we  = 1'b0;
    sp_wr_en   = 1'b0;
    sp_wr_data = wr_data;
    if (wr_en) begin
      case (wr_idx)
        CR_STATUS: begin
          stat_we = 1'b1;
          cond_we = 1'b1;
          if (mode_flip) begin
            sp_wr_en = 1'b1;
            if (wr_data[MODE_BIT]) begin
              usp_we     = 1'b1;
              usp_val    = sp_rd_data;
              sp_wr_data = isp_q;
            end else begin
              isp_we     = 1'b1;
              isp_val    = sp_rd_data;
              sp_wr_data = usp_q;
            end
          end
        end
        CR_COND: cond_we = 1'b1;
        CR_ISP: begin
          if (stack_mode) sp_wr_en = 1'b1;
          else            isp_we   = 1'b1;
        end
        CR_USP: begin
          if (!stack_mode) sp_wr_en = 1'b1;
          else             usp_we   = 1'b1;
        end
        CR_BPC:    bpc_we    = 1'b1;
        CR_BBPC:   bbpc_we   = 1'b1;
        CR_BBSTAT: bbstat_we = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_SPARE; g++) begin : g_spare_we
    assign spare_we[g] = wr_en && (wr_idx == IDX_W'(SPARE_BASE + g));
  end
endmodule

// File: rtl/crf_regs.sv
module crf_regs
  import ctrl_regfile_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SPARE = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              stat_we,
  input  logic                              cond_we,
  input  logic                              isp_we,
  input  logic [DATA_W-1:0]                 isp_val,
  input  logic                              usp_we,
  input  logic [DATA_W-1:0]                 usp_val,
  input  logic                              bpc_we,
  input  logic                              bbpc_we,
  input  logic                              bbstat_we,
  input  logic [NUM_SPARE-1:0]              spare_we,
  output logic [1:0]                        stat_hi_q,
  output logic [7:0]                        bstat_q,
  output logic [7:0]                        bbstat_q,
  output logic                              cond_q,
  output logic [DATA_W-1:0]                 isp_q,
  output logic [DATA_W-1:0]                 usp_q,
  output logic [DATA_W-1:0]                 bpc_q,
  output logic [DATA_W-1:0]                 bbpc_q,
  output logic [NUM_SPARE-1:0][DATA_W-1:0]  spare_q
);
  logic [1:0]                       stat_hi_d;
  logic [7:0]                       bstat_d;
  logic [7:0]                       bbstat_d;
  logic                             cond_d;
  logic [DATA_W-1:0]                isp_d;
  logic [DATA_W-1:0]                usp_d;
  logic [DATA_W-1:0]                bpc_d;
  logic [DATA_W-1:0]                bbpc_d;
  logic [NUM_SPARE-1:0][DATA_W-1:0] spare_d;

  // next state, clock enables written out
  always_comb begin
    stat_hi_d = stat_we   ? wr_data[7:6]  : stat_hi_q;
    bstat_d   = stat_we   ? wr_data[15:8] : bstat_q;
    bbstat_d  = bbstat_we ? wr_data[7:0]  : bbstat_q;
    cond_d    = cond_we   ? wr_data[0]    : cond_q;
    isp_d     = isp_we    ? isp_val       : isp_q;
    usp_d     = usp_we    ? usp_val       : usp_q;
    bpc_d     = bpc_we    ? wr_data       : bpc_q;
    bbpc_d    = bbpc_we   ? wr_data       : bbpc_q;
    for (int i = 0; i < NUM_SPARE; i++) begin
      spare_d[i] = spare_we[i] ? wr_data : spare_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_hi_q <= '0;
      bstat_q   <= '0;
      bbstat_q  <= '0;
      cond_q    <= 1'b0;
      isp_q     <= '0;
      usp_q     <= '0;
      bpc_q     <= '0;
      bbpc_q    <= '0;
      spare_q   <= '0;
    end else begin
      stat_hi_q <= stat_hi_d;
      bstat_q   <= bstat_d;
      bbstat_q  <= bbstat_d;
      cond_q    <= cond_d;
      isp_q     <= isp_d;
      usp_q     <= usp_d;
      bpc_q     <= bpc_d;
      bbpc_q    <= bbpc_d;
      spare_q   <= spare_d;
    end
  end
endmodule

// File: rtl/crf_rd_mux.sv
module crf_rd_mux
  import ctrl_regfile_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SPARE = 2
) (
  input  logic [IDX_W-1:0]                  rd_idx,
  input  logic [1:0]                        stat_hi_q,
  input  logic [7:0]                        bstat_q,
  input  logic [7:0]                        bbstat_q,
  input  logic                              cond_q,
  input  logic [DATA_W-1:0]                 isp_q,
  input  logic [DATA_W-1:0]                 usp_q,
  input  logic [DATA_W-1:0]                 bpc_q,
  input  logic [DATA_W-1:0]                 bbpc_q,
  input  logic [NUM_SPARE-1:0][DATA_W-1:0]  spare_q,
  input  logic [DATA_W-1:0]                 sp_rd_data,
  output logic [DATA_W-1:0]                 rd_data
);
  logic stack_mode;
  assign stack_mode = stat_hi_q[1];

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      CR_STATUS: begin
        rd_data[15:8] = bstat_q & FLAG_MASK;
        rd_data[7:6]  = stat_hi_q;
        rd_data[0]    = cond_q;
      end
      CR_COND:   rd_data[0]   = cond_q;
      CR_ISP:    rd_data      = stack_mode ? sp_rd_data : isp_q;
      CR_USP:    rd_data      = stack_mode ? usp_q : sp_rd_data;
      CR_BPC:    rd_data      = {bpc_q[DATA_W-1:1], 1'b0};
      CR_BBPC:   rd_data      = {bbpc_q[DATA_W-1:1], 1'b0};
      CR_BBSTAT: rd_data[7:0] = bbstat_q & FLAG_MASK;
      default: ;
    endcase
    for (int i = 0; i < NUM_SPARE; i++) begin
      if (rd_idx == IDX_W'(SPARE_BASE + i)) rd_data = spare_q[i];
    end
  end
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
  import ctrl_regfile_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SPARE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sp_rd_data,
  output logic              sp_wr_en,
  output logic [DATA_W-1:0] sp_wr_data
);
  logic                             rst_n_sync;
  logic                             stat_we, cond_we, isp_we, usp_we;
  logic                             bpc_we, bbpc_we, bbstat_we;
  logic [NUM_SPARE-1:0]             spare_we;
  logic [DATA_W-1:0]                isp_val, usp_val;
  logic [1:0]                       stat_hi_q;
  logic [7:0]                       bstat_q, bbstat_q;
  logic                             cond_q;
  logic [DATA_W-1:0]                isp_q, usp_q, bpc_q, bbpc_q;
  logic [NUM_SPARE-1:0][DATA_W-1:0] spare_q;
  logic                             stack_mode;

  assign stack_mode = stat_hi_q[1];

  crf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  crf_wr_decode #(.DATA_W(DATA_W), .NUM_SPARE(NUM_SPARE)) u_dec (
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .stack_mode (stack_mode),
    .sp_rd_data (sp_rd_data),
    .isp_q      (isp_q),
    .usp_q      (usp_q),
    .stat_we    (stat_we),
    .cond_we    (cond_we),
    .isp_we     (isp_we),
    .isp_val    (isp_val),
    .usp_we     (usp_we),
    .usp_val    (usp_val),
    .bpc_we     (bpc_we),
    .bbpc_we    (bbpc_we),
    .bbstat_we  (bbstat_we),
    .spare_we   (spare_we),
    .sp_wr_en   (sp_wr_en),
    .sp_wr_data (sp_wr_data)
  );

  crf_regs #(.DATA_W(DATA_W), .NUM_SPARE(NUM_SPARE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_data   (wr_data),
    .stat_we   (stat_we),
    .cond_we   (cond_we),
    .isp_we    (isp_we),
    .isp_val   (isp_val),
    .usp_we    (usp_we),
    .usp_val   (usp_val),
    .bpc_we    (bpc_we),
    .bbpc_we   (bbpc_we),
    .bbstat_we (bbstat_we),
    .spare_we  (spare_we),
    .stat_hi_q (stat_hi_q),
    .bstat_q   (bstat_q),
    .bbstat_q  (bbstat_q),
    .cond_q    (cond_q),
    .isp_q     (isp_q),
    .usp_q     (usp_q),
    .bpc_q     (bpc_q),
    .bbpc_q    (bbpc_q),
    .spare_q   (spare_q)
  );

  crf_rd_mux #(.DATA_W(DATA_W), .NUM_SPARE(NUM_SPARE)) u_rd (
    .rd_idx     (rd_idx),
    .stat_hi_q  (stat_hi_q),
    .bstat_q    (bstat_q),
    .bbstat_q   (bbstat_q),
    .cond_q     (cond_q),
    .isp_q      (isp_q),
    .usp_q      (usp_q),
    .bpc_q      (bpc_q),
    .bbpc_q     (bbpc_q),
    .spare_q    (spare_q),
    .sp_rd_data (sp_rd_data),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/ctrl_regfile_chk.sv
module ctrl_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] sp_rd_data,
  input logic              sp_wr_en,
  input logic              stack_mode
);
  AST_STATUS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 4'd0) |-> (rd_data[DATA_W-1:16] == '0 && rd_data[13:9] == '0 && rd_data[5:1] == '0)); // R1

  AST_STATUS_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd0) |=> (stack_mode == $past(wr_data[7]))); // R2

  AST_RISE_SWAPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd0 && wr_data[7] && !stack_mode) |-> sp_wr_en); // R3

  AST_FALL_SWAPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd0 && !wr_data[7] && stack_mode) |-> sp_wr_en); // R4

  AST_SAME_MODE_NO_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd0 && (wr_data[7] == stack_mode)) |-> !sp_wr_en); // R4

  AST_SP_WR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> wr_en); // R5

  AST_ACTIVE_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ((stack_mode && rd_idx == 4'd2) || (!stack_mode && rd_idx == 4'd3)) |-> (rd_data == sp_rd_data)); // R5

  AST_BPC_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 4'd6 || rd_idx == 4'd9) |-> !rd_data[0]); // R6

  AST_BBSTAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 4'd8) |-> ((rd_data & ~DATA_W'(32'hC1)) == '0)); // R7

  AST_COND_READ_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 4'd1) |-> (rd_data[DATA_W-1:1] == '0)); // R8

  AST_COND_WR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd1) |=> $stable(stack_mode)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 4'd7 || rd_idx > 4'd9) |-> (rd_data == '0)); // R10

  AST_UNMAPPED_NO_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == 4'd7 || wr_idx > 4'd9)) |-> !sp_wr_en); // R10
endmodule

bind ctrl_regfile ctrl_regfile_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .rd_idx     (rd_idx),
  .rd_data    (rd_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .sp_rd_data (sp_rd_data),
  .sp_wr_en   (sp_wr_en),
  .stack_mode (stack_mode)
);

// File: tb/ctrl_regfile_tb_top.sv
module ctrl_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [31:0] r15;
  logic        sp_wr_en;
  logic [31:0] sp_wr_data;
  logic        gpr_we;
  logic [31:0] gpr_wd;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model of the architectural state
  logic [7:0]  m_stat, m_bstat, m_bbstat;
  logic        m_cond;
  logic [31:0] m_isp, m_usp, m_bpc, m_bbpc, m_sp4, m_sp5, m_r15;

  always #5 clk = ~clk;

  // R15 in the general register file: side-port writes and other instructions
  always @(posedge clk) begin
    if (sp_wr_en)    r15 <= sp_wr_data;
    else if (gpr_we) r15 <= gpr_wd;
  end

  ctrl_regfile dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .sp_rd_data (r15),
    .sp_wr_en   (sp_wr_en),
    .sp_wr_data (sp_wr_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] idx);
    case (idx)
      4'd0:       return "R1 status read";
      4'd1:       return "R8 cond read";
      4'd2, 4'd3: return "R5 stack pointer read";
      4'd4, 4'd5: return "R9 spare read";
      4'd6, 4'd9: return "R6 backup pc read";
      4'd8:       return "R7 second backup status read";
      default:    return "R10 unmapped read";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] idx);
    logic [31:0] r;
    r = '0;
    case (idx)
      4'd0: begin r[15:8] = m_bstat & 8'hC1; r[7:6] = m_stat[7:6]; r[0] = m_cond; end
      4'd1: r[0] = m_cond;
      4'd2: r = m_stat[7] ? m_r15 : m_isp;
      4'd3: r = m_stat[7] ? m_usp : m_r15;
      4'd4: r = m_sp4;
      4'd5: r = m_sp5;
      4'd6: r = m_bpc & 32'hFFFF_FFFE;
      4'd8: r[7:0] = m_bbstat & 8'hC1;
      4'd9: r = m_bbpc & 32'hFFFF_FFFE;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic do_read(input logic [3:0] idx);
    logic [31:0] e;
    @(negedge clk);
    rd_idx = idx;
    #1;
    e = exp_read(idx);
    check(rd_data === e, tag_of(idx), rd_data, e);
  endtask

  task automatic set_r15(input logic [31:0] v);
    @(negedge clk);
    gpr_we = 1'b1;
    gpr_wd = v;
    @(posedge clk);
    #1 gpr_we = 1'b0;
    m_r15 = v;
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [31:0] d);
    logic        e_en;
    logic [31:0] e_d;
    logic        sm;
    string       tg;
    sm   = m_stat[7];
    e_en = 1'b0;
    e_d  = d;
    tg   = "R5 side port";
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    #1;
    case (idx)
      4'd0: begin
        tg = (d[7] && !sm) ? "R3 side port" : "R4 side port";
        if (d[7] != sm) begin
          e_en = 1'b1;
          if (d[7]) begin e_d = m_isp; m_usp = m_r15; end
          else      begin e_d = m_usp; m_isp = m_r15; end
          m_r15 = e_d;
        end
        m_bstat = d[15:8]; m_stat = d[7:0]; m_cond = d[0];
      end
      4'd1: m_cond = d[0];
      4'd2: if (sm)  begin e_en = 1'b1; m_r15 = d; end else m_isp = d;
      4'd3: if (!sm) begin e_en = 1'b1; m_r15 = d; end else m_usp = d;
      4'd4: m_sp4 = d;
      4'd5: m_sp5 = d;
      4'd6: m_bpc = d;
      4'd8: m_bbstat = d[7:0];
      4'd9: m_bbpc = d;
      default: tg = "R10 side port";
    endcase
    check(sp_wr_en === e_en, tg, {31'b0, sp_wr_en}, {31'b0, e_en});
    if (e_en) check(sp_wr_data === e_d, tg, sp_wr_data, e_d);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic check_r15(input string tg);
    @(negedge clk);
    check(r15 === m_r15, tg, r15, m_r15);
  endtask

  function automatic logic [3:0] pick_idx();
    int k;
    k = int'($urandom_range(0, 9));
    if (k < 4) return 4'd0;
    if (k < 6) return 4'(2 + (k % 2));
    return 4'($urandom_range(0, 15));
  endfunction

  initial begin : wdog
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7919));
    rst_n = 1'b0; rd_idx = '0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    gpr_we = 1'b0; gpr_wd = '0; r15 = '0;
    m_stat = '0; m_bstat = '0; m_bbstat = '0; m_cond = 1'b0;
    m_isp = '0; m_usp = '0; m_bpc = '0; m_bbpc = '0; m_sp4 = '0; m_sp5 = '0; m_r15 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11: all readable state is zero after reset
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      #1;
      check(rd_data === exp_read(4'(i)), "R11 reset value", rd_data, exp_read(4'(i)));
    end

    // R5: user alias while in user mode, interrupt shadow stored
    set_r15(32'hAAAA_0000);
    do_write(4'd3, 32'h0000_2000);
    check_r15("R5 user alias write");
    do_write(4'd2, 32'h1000_0100);
    do_read(4'd2);
    do_read(4'd3);

    // R3: enter stack mode 1, R2 status fields loaded
    do_write(4'd0, 32'h0000_FFC1);
    check_r15("R3 live sp loaded from interrupt shadow");
    do_read(4'd0);
    do_read(4'd3);
    do_read(4'd2);
    // R4: same-mode status write leaves the stack pointer alone
    do_write(4'd0, 32'h0000_3E80);
    check_r15("R4 no swap on same mode");
    do_read(4'd0);
    // R5: interrupt alias while in stack mode 1
    do_write(4'd2, 32'h1234_5678);
    check_r15("R5 interrupt alias write");
    do_write(4'd3, 32'h5555_0004);
    do_read(4'd3);
    // R4: leave stack mode
    do_write(4'd0, 32'h0000_0000);
    check_r15("R4 live sp loaded from user shadow");
    do_read(4'd2);
    do_read(4'd0);

    // R8: cond write leaves status bits alone
    do_write(4'd0, 32'h0000_C040);
    do_write(4'd1, 32'hFFFF_FFFF);
    do_read(4'd0);
    do_read(4'd1);
    do_write(4'd1, 32'hFFFF_FFFE);
    do_read(4'd1);

    // R6, R7, R9
    do_write(4'd6, 32'hFFFF_FFFF);
    do_read(4'd6);
    do_write(4'd9, 32'h8000_0003);
    do_read(4'd9);
    do_write(4'd8, 32'h0000_01FF);
    do_read(4'd8);
    do_write(4'd4, 32'hDEAD_BEEF);
    do_write(4'd5, 32'h0123_4567);
    do_read(4'd4);
    do_read(4'd5);

    // R10: unmapped writes change nothing
    do_write(4'd7, 32'hFFFF_FFFF);
    do_write(4'd15, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) do_read(4'(i));

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 5)       do_write(pick_idx(), $urandom());
      else if (op < 9)  do_read(pick_idx());
      else              set_r15($urandom());
      if ((n % 16) == 0) check_r15("R5 live sp tracking");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule